// File: doc/BRIEF.md
# Handshaked Processor Liveness Watchdog

This block decides whether a processor is still alive by trading a request and an acknowledge through a shared register file. Out of reset it does nothing. It arms the first time the processor writes the watchdog register, which is entry 0 of that register file. The register file is not part of the block. The block sees the processor's register writes through a write strobe and an address. It talks to the register file through a request output and an acknowledge input.

Once armed, the block repeats a check. It raises a one-cycle update request, then waits for the acknowledge while a timeout counter runs. An acknowledge in time starts the next check. If the wait window runs out with no acknowledge, the processor is taken as dead. The block then pulses a reset request for one cycle, sets a dead flag that holds until block reset, and goes back to the unarmed state. A later write to entry 0 arms it again.

Top module: `proc_liveness_wdog`

## Requirements
- R1: While reset is held, and in the first cycle after it, `upd_req`, `rst_req` and `dead` are all 0.
- R2: Until the block is armed, `upd_req` stays 0. Writes to any address other than 0 do not arm it, and neither does `upd_ack`.
- R3: A write with `reg_wr_addr` equal to 0, sampled while unarmed, makes `upd_req` high for exactly the one following cycle.
- R4: After an update request, the next 2^CNT_W cycles form the wait window. If `upd_ack` is high in one of them, `upd_req` is high again in the following cycle and a fresh full window follows.
- R5: An acknowledge in the last cycle of the window, which is the cycle in which the counter would overflow, counts as on time. No reset request follows from it.
- R6: If no acknowledge arrives in the whole window, `rst_req` is high for exactly one cycle: the cycle right after the window. `dead` becomes 1 in that same cycle.
- R7: `dead` stays 1 until block reset. After a timeout the block is unarmed again and ignores `upd_ack`. A new write to address 0 re-arms it without clearing `dead`, and a second timeout pulses `rst_req` again.
- R8: A write to address 0 while the block is armed has no effect on the request and timeout timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Processor register-file write strobe |
| reg_wr_addr | input | ADDR_W | Register-file entry being written |
| upd_ack | input | 1 | "Updated" acknowledge from the register file |
| upd_req | output | 1 | One-cycle update request to the register file |
| rst_req | output | 1 | One-cycle processor reset request on timeout |
| dead | output | 1 | Sticky processor-dead flag |

## Verification
The bench builds the block with CNT_W = 4 and ADDR_W = 3. The 16-cycle wait window therefore lets it reach overflow, the acknowledge that lands exactly at overflow, and two full timeouts with re-arming in a few hundred cycles. The 16-bit default would need about 65,000 cycles per timeout. The three-bit address lets the bench show that writes to nonzero entries leave the block unarmed.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    WD_DORMANT = 2'd0,
    WD_POST    = 2'd1,
    WD_WAIT    = 2'd2
  } wd_state_t;

endpackage

// File: rtl/wdog_arm_decode.sv
module wdog_arm_decode #(
  parameter int ADDR_W = 4,
  parameter int ENTRY  = 0
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] ENTRY_ADDR = ENTRY[ADDR_W-1:0];

  function automatic logic addr_matches(input logic [ADDR_W-1:0] a);
    return a == ENTRY_ADDR;
  endfunction

  assign hit = wr_en & addr_matches(wr_addr);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic last
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic cnt_at_end(input logic [CNT_W-1:0] c);
    return c == CNT_MAX;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (run) cnt <= cnt_step(cnt);
  end

  assign last = cnt_at_end(cnt);
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_hit,
  input  logic ack,
  input  logic tmr_last,
  output logic tmr_clr,
  output logic tmr_run,
  output logic upd_req,
  output logic rst_req,
  output logic dead,
  output logic st_dormant,
  output logic st_wait,
  output logic ack_taken,
  output logic timeout_evt
);
  wd_state_t st, st_n;
  logic      rst_req_q, dead_q;

  always_comb begin
    st_n        = st;
    ack_taken   = 1'b0;
    timeout_evt = 1'b0;
    unique case (st)
      WD_DORMANT: if (arm_hit) st_n = WD_POST;
      WD_POST:    st_n = WD_WAIT;
      WD_WAIT: begin
        if (ack) begin
          ack_taken = 1'b1;
          st_n      = WD_POST;
        end else if (tmr_last) begin
          timeout_evt = 1'b1;
          st_n        = WD_DORMANT;
        end
      end
      default:    st_n = WD_DORMANT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= WD_DORMANT;
      rst_req_q <= 1'b0;
      dead_q    <= 1'b0;
    end else begin
      st        <= st_n;
      rst_req_q <= timeout_evt;
      dead_q    <= dead_q | timeout_evt;
    end
  end

  assign st_dormant = (st == WD_DORMANT);
  assign st_wait    = (st == WD_WAIT);
  assign tmr_run    = st_wait;
  assign tmr_clr    = ~st_wait | ack_taken;
  assign upd_req    = (st == WD_POST);
  assign rst_req    = rst_req_q;
  assign dead       = dead_q;
endmodule

// File: rtl/proc_liveness_wdog.sv
module proc_liveness_wdog #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int ENTRY  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic              upd_ack,
  output logic              upd_req,
  output logic              rst_req,
  output logic              dead
);
  logic arm_hit;
  logic tmr_clr, tmr_run, tmr_last;
  logic st_dormant, st_wait, ack_taken, timeout_evt;

  wdog_arm_decode #(.ADDR_W(ADDR_W), .ENTRY(ENTRY)) u_decode (
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .hit     (arm_hit)
  );

  wdog_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .run   (tmr_run),
    .last  (tmr_last)
  );

  wdog_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_hit     (arm_hit),
    .ack         (upd_ack),
    .tmr_last    (tmr_last),
    .tmr_clr     (tmr_clr),
    .tmr_run     (tmr_run),
    .upd_req     (upd_req),
    .rst_req     (rst_req),
    .dead        (dead),
    .st_dormant  (st_dormant),
    .st_wait     (st_wait),
    .ack_taken   (ack_taken),
    .timeout_evt (timeout_evt)
  );
endmodule

// File: rtl/wdog_liveness_chk.sv
module wdog_liveness_chk (
  input logic clk,
  input logic rst_n,
  input logic upd_req,
  input logic upd_ack,
  input logic rst_req,
  input logic dead,
  input logic arm_hit,
  input logic st_dormant,
  input logic st_wait,
  input logic ack_taken,
  input logic tmr_last,
  input logic timeout_evt
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |=> !upd_req); // R3
  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |-> ($past(arm_hit && st_dormant) || $past(ack_taken))); // R2
  AST_ACK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wait && upd_ack) |=> (upd_req && !rst_req)); // R4
  AST_ACK_AT_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wait && upd_ack && tmr_last) |=> !rst_req); // R5
  AST_OVERFLOW_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wait && !upd_ack && tmr_last) |=> (rst_req && dead)); // R6
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R6
  AST_RST_FROM_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(timeout_evt)); // R6
  AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dead |=> dead); // R7
  AST_DORMANT_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> st_dormant); // R7
endmodule

bind proc_liveness_wdog wdog_liveness_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .upd_req     (upd_req),
  .upd_ack     (upd_ack),
  .rst_req     (rst_req),
  .dead        (dead),
  .arm_hit     (arm_hit),
  .st_dormant  (st_dormant),
  .st_wait     (st_wait),
  .ack_taken   (ack_taken),
  .tmr_last    (tmr_last),
  .timeout_evt (timeout_evt)
);

// File: tb/proc_liveness_wdog_bench.sv
`timescale 1ns/1ps
module proc_liveness_wdog_bench;
  localparam int CW  = 4;
  localparam int AW  = 3;
  localparam int WIN = 1 << CW;
  localparam int EV_REQ = 1;
  localparam int EV_RST = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [AW-1:0] reg_wr_addr = '0;
  logic upd_ack = 1'b0;
  logic upd_req, rst_req, dead;

  always #2 clk = ~clk;

  proc_liveness_wdog #(.CNT_W(CW), .ADDR_W(AW), .ENTRY(0)) u_proc_liveness_wdog (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .upd_ack(upd_ack), .upd_req(upd_req), .rst_req(rst_req), .dead(dead)
  );

  typedef struct { int kind; int at; string req; } ev_t;
  ev_t exp_q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int n_seen = 0;
  int exp_req = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic compare_ev(input int kind);
    ev_t e;
    n_chk++;
    n_seen++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL R2/R6: actual event kind %0d at cycle %0d expected no event", kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        n_bad++;
        $display("FAIL %s: actual kind %0d at cycle %0d expected kind %0d at cycle %0d",
                 e.req, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  // monitor: outputs are registered, so negedge sampling is order-safe
  always @(negedge clk) begin
    if (rst_n) begin
      if (upd_req) compare_ev(EV_REQ);
      if (rst_req) compare_ev(EV_RST);
    end
  end

  task automatic push(input int kind, input int at, input string req);
    ev_t e;
    e.kind = kind; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic write_reg(input logic [AW-1:0] a, output int at);
    reg_wr_en = 1'b1; reg_wr_addr = a; at = cyc;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_addr = '0;
  endtask

  task automatic arm(input string req);
    int n;
    push(EV_REQ, cyc + 1, req);
    write_reg('0, n);
    exp_req = n + 1;
  endtask

  task automatic ack_at(input int k, input string req);
    int t;
    t = exp_req + 1 + k;
    push(EV_REQ, t + 1, req);
    wait_until(t);
    upd_ack = 1'b1;
    @(negedge clk);
    upd_ack = 1'b0;
    exp_req = t + 1;
  endtask

  task automatic expect_timeout();
    int t;
    t = exp_req + 1 + WIN;
    push(EV_RST, t, "R6");
    wait_until(t);
    check("R6 dead set with pulse", int'(dead), 1);
    @(negedge clk);
    check("R6 rst_req one cycle", int'(rst_req), 0);
    check("R7 dead holds", int'(dead), 1);
  endtask

  initial begin
    int n, seen0;
    repeat (3) @(negedge clk);
    check("R1 upd_req in reset", int'(upd_req), 0);
    check("R1 rst_req in reset", int'(rst_req), 0);
    check("R1 dead in reset", int'(dead), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 dead after reset", int'(dead), 0);

    // R2: nonzero addresses and stray acks do not arm
    seen0 = n_seen;
    write_reg(3'd3, n);
    write_reg(3'd5, n);
    upd_ack = 1'b1; @(negedge clk); upd_ack = 1'b0;
    repeat (25) @(negedge clk);
    check("R2 no request while unarmed", n_seen - seen0, 0);

    // R3 arm, R4 acks early and mid-window, R5 ack at overflow
    arm("R3");
    ack_at(0, "R4");
    ack_at(5, "R4");
    ack_at(WIN - 1, "R5");
    ack_at(WIN - 1, "R5");
    check("R5 no reset after late ack", int'(rst_req), 0);
    check("R5 not dead", int'(dead), 0);

    // R8: rewriting entry 0 while armed leaves timing alone
    repeat (4) @(negedge clk);
    write_reg('0, n);
    write_reg('0, n);
    expect_timeout();

    // R7: unarmed after timeout, acks ignored
    seen0 = n_seen;
    upd_ack = 1'b1; @(negedge clk); upd_ack = 1'b0;
    repeat (3 * WIN) @(negedge clk);
    check("R7 no request after timeout", n_seen - seen0, 0);
    check("R7 dead still set", int'(dead), 1);

    // R7: re-arm, dead persists, second timeout pulses again
    arm("R7");
    @(negedge clk);
    check("R7 dead kept on re-arm", int'(dead), 1);
    ack_at(2, "R7");
    expect_timeout();

    // R1: block reset clears dead
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 dead cleared by reset", int'(dead), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 all expected events seen", exp_q.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule